// File: doc/BRIEF.md
# Raster Sync and Data-Enable Generator

This block produces the line and frame timing for a parallel RGB panel, clocked by the pixel clock. Two copies of one small phase machine run in cascade. The horizontal machine steps once per pixel clock. The vertical machine steps once per completed line. Each machine walks through four named phases, and each phase lasts a programmed number of units.

From the two phase states the block derives a horizontal sync, a vertical sync and a data-enable. It also gates a 24-bit pixel input onto the pixel output. Either sync pin can carry a composite pulse, formed as the OR of both sync pulses, in place of its own pulse. Either pin can be made active-low.

All timing lengths, polarities and composite selections are taken into a shadow copy only on the first pixel of a frame. A change made to the configuration inputs in the middle of a frame therefore takes effect at the next frame boundary.

Top module: `disp_timing_gen`

Each axis machine has four states, visited in a fixed order:
- SYNC lasts `sync` units and moves to BACK.
- BACK lasts `back` units and moves to ACTIVE.
- ACTIVE lasts `active` units and moves to FRONT.
- FRONT lasts `front` units and moves back to SYNC. This last transition is the wrap: it ends a line on the horizontal axis and ends a frame on the vertical axis.

A unit is one pixel clock on the horizontal axis and one line on the vertical axis.

## Requirements
- R1: Each axis visits its phases in the order SYNC, BACK, ACTIVE, FRONT and then repeats. Every phase lasts exactly its programmed length, and every length must be at least 1. A line is therefore hsync+hback+hactive+hfront pixel clocks long, and a frame is vsync+vback+vactive+vfront lines long.
- R2: The plain horizontal sync is active from the first pixel clock of every line and stays active for the programmed horizontal sync length.
- R3: The plain vertical sync becomes active on the first pixel clock of a frame and stays active for the programmed number of whole lines.
- R4: When `cfg_hs_composite` is 1, the `hsync` pin carries the OR of the active-level horizontal and vertical pulses. `cfg_vs_composite` does the same for the `vsync` pin. With the bit at 0, the pin carries its own plain pulse.
- R5: A polarity bit of 0 drives the pin high while its pulse is active. A polarity bit of 1 inverts the pin so that it is active-low. The OR for composite sync is taken before the inversion.
- R6: `de` is 1 exactly when both axes are in their ACTIVE phase, and 0 at all other times.
- R7: While `de` is 1, `pix_out` equals `pix_in`, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0, and the most significant bit of each colour at the top of its field. While `de` is 0, `pix_out` is all zeros.
- R8: All lengths, polarities and composite selections are taken from the configuration inputs only on the first pixel clock of a frame, and that same cycle already uses the new values. Changes at any other time have no effect until the next frame starts.
- R9: While `rst_n` is low, and on the first cycle after it is released, both axes sit at the first pixel of a frame: both sync pulses are active and `de` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_active | input | 12 | Visible pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch, in pixels |
| cfg_h_sync | input | 12 | Horizontal sync width, in pixels |
| cfg_h_back | input | 12 | Horizontal back porch, in pixels |
| cfg_v_active | input | 11 | Visible lines per frame |
| cfg_v_front | input | 11 | Vertical front porch, in lines |
| cfg_v_sync | input | 11 | Vertical sync width, in lines |
| cfg_v_back | input | 11 | Vertical back porch, in lines |
| cfg_hs_polarity | input | 1 | 1 makes the hsync pin active-low |
| cfg_vs_polarity | input | 1 | 1 makes the vsync pin active-low |
| cfg_hs_composite | input | 1 | 1 puts composite sync on the hsync pin |
| cfg_vs_composite | input | 1 | 1 puts composite sync on the vsync pin |
| pix_in | input | 24 | Pixel data, red 23:16, green 15:8, blue 7:0 |
| hsync | output | 1 | Horizontal or composite sync pin |
| vsync | output | 1 | Vertical or composite sync pin |
| de | output | 1 | Data enable |
| pix_out | output | 24 | Gated pixel data |

## Verification
A wrong phase count or a missed transition in the horizontal machine moves the edges of `hsync` and `de` within the same line. It is therefore visible within one line period. A fault in the vertical machine, or in the frame-boundary capture of the shadow, shows up only as a misplaced sync or enable line, or as a configuration change that lands too early. It can take up to a full frame to appear. For this reason the reference model compares every pin on every clock across several frames, including frames whose configuration was altered mid-frame.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
    localparam int COMP_W = 8;
    localparam int PIX_W  = 3 * COMP_W;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;
endpackage

// File: rtl/disp_axis_fsm.sv
module disp_axis_fsm
    import disp_timing_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_active,
    input  logic [W-1:0] len_front,
    output phase_e       phase,
    output logic         first,
    output logic         wrap
);
    phase_e       phase_q, phase_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] cur_len;
    logic         at_end;

    always_comb begin
        unique case (phase_q)
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_back;
            PH_ACTIVE: cur_len = len_active;
            PH_FRONT:  cur_len = len_front;
            default:   cur_len = len_sync;
        endcase
        at_end  = (cnt_q == cur_len - W'(1));
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (adv) begin
            if (at_end) begin
                cnt_d = '0;
                unique case (phase_q)
                    PH_SYNC:   phase_d = PH_BACK;
                    PH_BACK:   phase_d = PH_ACTIVE;
                    PH_ACTIVE: phase_d = PH_FRONT;
                    PH_FRONT:  phase_d = PH_SYNC;
                    default:   phase_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase = phase_q;
        first = (phase_q == PH_SYNC) && (cnt_q == '0);
        wrap  = adv && at_end && (phase_q == PH_FRONT);
    end

    // R1: phases only ever step forward in the fixed order
    assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));

    // R1: the count inside a phase never reaches the phase length
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < cur_len);
endmodule

// File: rtl/disp_sync_out.sv
module disp_sync_out
    import disp_timing_pkg::*;
#(
    parameter int PW = PIX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        h_phase,
    input  phase_e        v_phase,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          hs_comp,
    input  logic          vs_comp,
    input  logic [PW-1:0] pix_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [PW-1:0] pix_o
);
    logic hs_act, vs_act, comp_act;

    always_comb begin
        hs_act   = (h_phase == PH_SYNC);
        vs_act   = (v_phase == PH_SYNC);
        comp_act = hs_act | vs_act;
        hsync_o  = (hs_comp ? comp_act : hs_act) ^ hs_pol;
        vsync_o  = (vs_comp ? comp_act : vs_act) ^ vs_pol;
        de_o     = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        pix_o    = de_o ? pix_i : '0;
    end

    // R4: composite on the hsync pin must show the vertical pulse too
    assert_comp_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_comp && vs_act) |-> (hsync_o == !hs_pol));

    // R6: no data enable while either axis is in sync
    assert_de_outside_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !(hs_act || vs_act));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_timing_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [H_W-1:0]   cfg_h_active,
    input  logic [H_W-1:0]   cfg_h_front,
    input  logic [H_W-1:0]   cfg_h_sync,
    input  logic [H_W-1:0]   cfg_h_back,
    input  logic [V_W-1:0]   cfg_v_active,
    input  logic [V_W-1:0]   cfg_v_front,
    input  logic [V_W-1:0]   cfg_v_sync,
    input  logic [V_W-1:0]   cfg_v_back,
    input  logic             cfg_hs_polarity,
    input  logic             cfg_vs_polarity,
    input  logic             cfg_hs_composite,
    input  logic             cfg_vs_composite,
    input  logic [PIX_W-1:0] pix_in,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [PIX_W-1:0] pix_out
);
    localparam int CFG_W = 4 * H_W + 4 * V_W + 4;

    logic [CFG_W-1:0] cfg_w, shadow_q, eff;
    logic [H_W-1:0]   e_ha, e_hf, e_hs, e_hb;
    logic [V_W-1:0]   e_va, e_vf, e_vs, e_vb;
    logic             e_hpol, e_vpol, e_hcomp, e_vcomp;
    phase_e           h_phase, v_phase;
    logic             h_first, h_wrap, v_first, v_wrap, frame_start;

    assign cfg_w = {cfg_h_active, cfg_h_front, cfg_h_sync, cfg_h_back,
                    cfg_v_active, cfg_v_front, cfg_v_sync, cfg_v_back,
                    cfg_hs_polarity, cfg_vs_polarity, cfg_hs_composite, cfg_vs_composite};

    assign frame_start = h_first && v_first;
    assign eff = frame_start ? cfg_w : shadow_q;
    assign {e_ha, e_hf, e_hs, e_hb, e_va, e_vf, e_vs, e_vb,
            e_hpol, e_vpol, e_hcomp, e_vcomp} = eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           shadow_q <= '0;
        else if (frame_start) shadow_q <= cfg_w;
    end

    disp_axis_fsm #(.W(H_W)) u_h_axis (
        .clk(clk), .rst_n(rst_n), .adv(1'b1),
        .len_sync(e_hs), .len_back(e_hb), .len_active(e_ha), .len_front(e_hf),
        .phase(h_phase), .first(h_first), .wrap(h_wrap)
    );

    disp_axis_fsm #(.W(V_W)) u_v_axis (
        .clk(clk), .rst_n(rst_n), .adv(h_wrap),
        .len_sync(e_vs), .len_back(e_vb), .len_active(e_va), .len_front(e_vf),
        .phase(v_phase), .first(v_first), .wrap(v_wrap)
    );

    disp_sync_out #(.PW(PIX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .h_phase(h_phase), .v_phase(v_phase),
        .hs_pol(e_hpol), .vs_pol(e_vpol), .hs_comp(e_hcomp), .vs_comp(e_vcomp),
        .pix_i(pix_in), .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_o(pix_out)
    );

    // R8: the shadow copy moves only at a frame boundary
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(shadow_q));

    // R3: the end of the last line is followed by a frame start
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |=> frame_start);

    // R3: vertical sync can only begin on the first pixel of a line
    assert_vs_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_phase == PH_SYNC) |-> h_first);
endmodule

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/100ps
module disp_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ha, hf, hs, hb;
    logic [10:0] va, vf, vs, vb;
    logic        hpol, vpol, hcomp, vcomp;
    logic [23:0] pix_in = '0;
    logic        hsync, vsync, de;
    logic [23:0] pix_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // model state
    int hx = 0, vy = 0;
    int sh[8];
    bit sp[4];

    always #2.5 clk = ~clk;

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_h_active(ha), .cfg_h_front(hf), .cfg_h_sync(hs), .cfg_h_back(hb),
        .cfg_v_active(va), .cfg_v_front(vf), .cfg_v_sync(vs), .cfg_v_back(vb),
        .cfg_hs_polarity(hpol), .cfg_vs_polarity(vpol),
        .cfg_hs_composite(hcomp), .cfg_vs_composite(vcomp),
        .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out)
    );

    // effective configuration seen by the model for the current position
    function automatic void eff(output int l[8], output bit p[4]);
        if (hx == 0 && vy == 0) begin
            l = '{int'(ha), int'(hf), int'(hs), int'(hb), int'(va), int'(vf), int'(vs), int'(vb)};
            p = '{hpol, vpol, hcomp, vcomp};
        end else begin
            l = sh;
            p = sp;
        end
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    always @(posedge clk) begin
        int l[8];
        bit p[4];
        if (!rst_n) begin
            hx = 0; vy = 0;
        end else begin
            eff(l, p);
            if (hx == 0 && vy == 0) begin sh = l; sp = p; end
            hx++;
            if (hx == l[0] + l[1] + l[2] + l[3]) begin
                hx = 0;
                vy++;
                if (vy == l[4] + l[5] + l[6] + l[7]) vy = 0;
            end
        end
    end

    always @(negedge clk) begin
        int l[8];
        bit p[4];
        bit ha_s, va_s, c, e_de;
        int e_h, e_v, e_pix;
        if (!rst_n) begin hx = 0; vy = 0; end
        eff(l, p);
        ha_s = hx < l[2];
        va_s = vy < l[6];
        c    = ha_s | va_s;
        e_h  = int'((p[2] ? c : ha_s) ^ p[0]);
        e_v  = int'((p[3] ? c : va_s) ^ p[1]);
        e_de = (hx >= l[2] + l[3]) && (hx < l[2] + l[3] + l[0]) &&
               (vy >= l[6] + l[7]) && (vy < l[6] + l[7] + l[4]);
        e_pix = e_de ? int'(pix_in) : 0;
        if (!rst_n) begin
            chk("R9 hsync in reset", int'(hsync), e_h);
            chk("R9 vsync in reset", int'(vsync), e_v);
            chk("R9 de in reset", int'(de), 0);
        end else begin
            chk("R2 R4 R5 R8 hsync", int'(hsync), e_h);
            chk("R3 R4 R5 R8 vsync", int'(vsync), e_v);
            chk("R1 R6 de", int'(de), int'(e_de));
            chk("R7 red field", int'(pix_out[23:16]), (e_pix >> 16) & 8'hff);
            chk("R7 green field", int'(pix_out[15:8]), (e_pix >> 8) & 8'hff);
            chk("R7 blue field", int'(pix_out[7:0]), e_pix & 8'hff);
        end
    end

    always @(posedge clk) begin
        #1 pix_in <= pix_in + 24'h0b0703;
    end

    task automatic setcfg(input int a, f, s, b, int la, lf, ls, lb, bit p0, p1, c0, c1);
        ha = 12'(a); hf = 12'(f); hs = 12'(s); hb = 12'(b);
        va = 11'(la); vf = 11'(lf); vs = 11'(ls); vb = 11'(lb);
        hpol = p0; vpol = p1; hcomp = c0; vcomp = c1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        setcfg(4, 2, 2, 3, 3, 1, 2, 1, 0, 0, 0, 0);
        run(3);
        // R9: release reset, first frame with plain active-high syncs
        rst_n = 1'b1;
        run(160);
        // R8: change mid-frame to inverted composite on hsync
        setcfg(5, 1, 3, 2, 2, 2, 1, 2, 1, 1, 1, 0);
        run(250);
        // R4 R5: composite on vsync, minimum lengths of one
        setcfg(3, 1, 1, 1, 2, 1, 1, 1, 0, 1, 0, 1);
        run(200);
        // both pins composite, wider line
        setcfg(9, 3, 4, 2, 4, 2, 3, 1, 1, 0, 1, 1);
        run(320);
        // R9: reset in the middle of a frame
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(200);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule